// File: doc/BRIEF.md
# Mode-Selected Arithmetic Logic Unit

A combinational ALU of parameterised width that covers twelve operations with two sections. The arithmetic section is a single ripple parallel adder. Its second operand is not B itself but a per-bit transform of B chosen by the two low select bits, and the carry input is added on top. That one adder gives transfer, increment, add, subtract and decrement. The logic section computes bitwise AND, OR, XOR and NOT A. A final multiplexer, steered by the high select bit, chooses which section drives the result.

The block is meant to sit between a register file's read ports and a write-back multiplexer. Its carry and overflow outputs feed status logic kept elsewhere. It holds no state, and an output settles in the same cycle as its inputs.

Top module: `mode_alu`

## Requirements
- R1: sel_i[2] chooses the section: 0 gives an arithmetic result, 1 gives a logic result. In arithmetic mode, result_o equals (a_i + Y + cin_i) modulo 2^WIDTH.
- R2: The adder operand Y is formed per bit from b_i using sel_i[1:0]: 00 gives all zeros, 01 gives b_i, 10 gives ~b_i, 11 gives all ones.
- R3: The eight arithmetic codes {sel_i[1:0], cin_i} give these results: 000 gives A, 001 gives A+1, 010 gives A+B, 011 gives A+B+1, 100 gives A+~B, 101 gives A-B, 110 gives A-1, 111 gives A.
- R4: In arithmetic mode, carry_o is the carry out of the adder's most significant bit. It equals bit WIDTH of a_i + Y + cin_i.
- R5: In arithmetic mode, overflow_o is 1 exactly when the carry into the most significant bit differs from the carry out of it. This happens when A and Y have the same sign and the result's sign differs from it.
- R6: In logic mode, sel_i[1:0] selects the operation: 00 gives a_i & b_i, 01 gives a_i | b_i, 10 gives a_i ^ b_i, 11 gives ~a_i.
- R7: In logic mode, cin_i has no effect on any output.
- R8: In logic mode, carry_o and overflow_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 3 | Select: bit 2 is the section, bits 1:0 are the operation |
| cin_i | input | 1 | Carry input to the adder |
| result_o | output | WIDTH | Result G |
| carry_o | output | 1 | Adder carry out, 0 in logic mode |
| overflow_o | output | 1 | Signed overflow, 0 in logic mode |

## Verification
The block holds no state, so an internal fault shows at the ports in the same cycle as the input that exposes it. A mis-decoded Y transform or a broken carry link gives a wrong result or a wrong carry for a few particular operand patterns only. For that reason, every select and carry-in combination is applied to many random operands and to the boundary operands 0x00, 0x7F, 0x80 and 0xFF. If the section multiplexer or the flag masking is wrong, logic mode shows a nonzero carry or overflow, or a result that changes when only cin_i changes.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;
  typedef enum logic [1:0] {
    Y_ZERO = 2'b00,
    Y_PASS = 2'b01,
    Y_INV  = 2'b10,
    Y_ONES = 2'b11
  } y_sel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } lg_sel_e;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned MODE_BIT = 2;
endpackage

// File: rtl/mode_alu_y_gen.sv
module mode_alu_y_gen #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] y_o
);
  import mode_alu_pkg::*;

  // one small mux per bit, shared select
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (y_sel_e'(sel_i))
        Y_ZERO:  y_o[i] = 1'b0;
        Y_PASS:  y_o[i] = b_i[i];
        Y_INV:   y_o[i] = ~b_i[i];
        default: y_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mode_alu_adder.sv
module mode_alu_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             c_msb_in_o
);
  logic [WIDTH:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ y_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & y_i[i]) | (c[i] & (a_i[i] ^ y_i[i]));
  end

  assign cout_o     = c[WIDTH];
  assign c_msb_in_o = c[WIDTH-1];
endmodule

// File: rtl/mode_alu_logic.sv
module mode_alu_logic #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o
);
  import mode_alu_pkg::*;

  always_comb begin
    unique case (lg_sel_e'(sel_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/mode_alu.sv
module mode_alu #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]                     a_i,
  input  logic [WIDTH-1:0]                     b_i,
  input  logic [mode_alu_pkg::SEL_W-1:0]       sel_i,
  input  logic                                 cin_i,
  output logic [WIDTH-1:0]                     result_o,
  output logic                                 carry_o,
  output logic                                 overflow_o
);
  import mode_alu_pkg::*;

  logic             logic_mode;
  logic [WIDTH-1:0] y;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             add_cout;
  logic             add_cmsb;

  assign logic_mode = sel_i[MODE_BIT];

  mode_alu_y_gen #(.WIDTH(WIDTH)) u_y_gen (
    .b_i   (b_i),
    .sel_i (sel_i[1:0]),
    .y_o   (y)
  );

  mode_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i        (a_i),
    .y_i        (y),
    .cin_i      (cin_i),
    .sum_o      (arith_res),
    .cout_o     (add_cout),
    .c_msb_in_o (add_cmsb)
  );

  mode_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i[1:0]),
    .res_o (logic_res)
  );

  assign result_o   = logic_mode ? logic_res : arith_res;
  // flags are meaningless for bitwise ops
  assign carry_o    = ~logic_mode & add_cout;
  assign overflow_o = ~logic_mode & (add_cout ^ add_cmsb);
endmodule

// File: rtl/mode_alu_checker.sv
module mode_alu_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       sel_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             overflow_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, sel_i, cin_i, result_o, carry_o, overflow_o});

  always_comb begin
    if (known && sel_i[2]) begin
      p_logic_flags_r8: assert (!carry_o && !overflow_o)
        else $error("logic mode flag set");
      if (sel_i[1:0] == 2'b00)
        p_logic_and_r6: assert (result_o == (a_i & b_i)) else $error("AND mismatch");
      if (sel_i[1:0] == 2'b11)
        p_logic_not_r6: assert (result_o == ~a_i) else $error("NOT mismatch");
    end
    if (known && !sel_i[2]) begin
      if (sel_i[1:0] == 2'b01)
        p_add_r3: assert (result_o == WIDTH'(a_i + b_i + WIDTH'(cin_i)))
          else $error("add mismatch");
      if (sel_i[1:0] == 2'b00 && !cin_i)
        p_transfer_r1: assert (result_o == a_i && !carry_o && !overflow_o)
          else $error("transfer mismatch");
      if (sel_i[1:0] == 2'b11 && cin_i)
        p_ones_carry_r4: assert (result_o == a_i && carry_o)
          else $error("A-1+1 carry mismatch");
      // overflow impossible when operands differ in sign (Y=B case)
      if (sel_i[1:0] == 2'b01 && (a_i[WIDTH-1] != b_i[WIDTH-1]))
        p_no_overflow_r5: assert (!overflow_o) else $error("spurious overflow");
    end
  end
endmodule

bind mode_alu mode_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .a_i        (a_i),
  .b_i        (b_i),
  .sel_i      (sel_i),
  .cin_i      (cin_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .overflow_o (overflow_o)
);

// File: tb/mode_alu_tb_top.sv
module mode_alu_tb_top;
  localparam int unsigned W = 8;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         ov;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [2:0]   sel = '0;
  logic         cin = 1'b0;
  logic [W-1:0] res;
  logic         cy, ov;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  mode_alu #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin),
    .result_o(res), .carry_o(cy), .overflow_o(ov)
  );

  function automatic exp_t model(logic [W-1:0] aa, logic [W-1:0] bb, logic [2:0] s, logic c);
    exp_t e;
    logic [W-1:0] y;
    logic [W:0]   sum;
    if (s[2]) begin
      case (s[1:0])  // R6
        2'b00: e.res = aa & bb;
        2'b01: e.res = aa | bb;
        2'b10: e.res = aa ^ bb;
        default: e.res = ~aa;
      endcase
      e.cy = 1'b0; e.ov = 1'b0;  // R8
      e.tag = "R6/R8";
    end else begin
      case (s[1:0])  // R2
        2'b00: y = '0;
        2'b01: y = bb;
        2'b10: y = ~bb;
        default: y = '1;
      endcase
      sum   = {1'b0, aa} + {1'b0, y} + {{W{1'b0}}, c};
      e.res = sum[W-1:0];                                   // R1
      e.cy  = sum[W];                                       // R4
      e.ov  = (aa[W-1] == y[W-1]) && (sum[W-1] != aa[W-1]); // R5
      e.tag = "R1/R2/R4/R5";
    end
    return e;
  endfunction

  task automatic drive(logic [W-1:0] aa, logic [W-1:0] bb, logic [2:0] s, logic c, string tag);
    exp_t e;
    @(posedge clk);
    a = aa; b = bb; sel = s; cin = c;
    e = model(aa, bb, s, c);
    if (tag != "") e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_direct(logic [W-1:0] got, logic [W-1:0] want, string tag);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, want);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (res !== e.res || cy !== e.cy || ov !== e.ov) begin
        failures++;
        $display("FAIL %s sel=%b cin=%b a=%h b=%h actual res=%h c=%b v=%b expected res=%h c=%b v=%b",
                 e.tag, sel, cin, a, b, res, cy, ov, e.res, e.cy, e.ov);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      done = 1;
      summary();
    end
  end

  initial begin
    logic [W-1:0] lr0;
    repeat (3) @(negedge clk);
    // reset state, inputs held at zero: transfer of 0 (R1)
    expect_direct(res, '0, "R1 reset result");
    expect_direct({{(W-2){1'b0}}, cy, ov}, '0, "R4 R5 reset flags");
    rst_ni = 1'b1;

    // R3 named arithmetic ops, directed operands
    drive(8'h5A, 8'h33, 3'b000, 1'b0, "R3 transfer");
    drive(8'h5A, 8'h33, 3'b000, 1'b1, "R3 increment");
    drive(8'h5A, 8'h33, 3'b001, 1'b0, "R3 add");
    drive(8'h5A, 8'h33, 3'b001, 1'b1, "R3 add plus one");
    drive(8'h5A, 8'h33, 3'b010, 1'b0, "R3 subtract with borrow");
    drive(8'h5A, 8'h33, 3'b010, 1'b1, "R3 subtract");
    drive(8'h5A, 8'h33, 3'b011, 1'b0, "R3 decrement");
    drive(8'h5A, 8'h33, 3'b011, 1'b1, "R3 transfer via ones");
    // corners
    drive(8'h7F, 8'h01, 3'b001, 1'b0, "R5 positive overflow");
    drive(8'h80, 8'hFF, 3'b001, 1'b0, "R5 negative overflow with carry");
    drive(8'hFF, 8'h01, 3'b001, 1'b0, "R4 carry wrap");
    drive(8'h80, 8'h01, 3'b010, 1'b1, "R5 subtract overflow");
    drive(8'h44, 8'h44, 3'b010, 1'b1, "R4 equal subtract carry");
    drive(8'h00, 8'h00, 3'b011, 1'b0, "R2 decrement zero");
    drive(8'hFF, 8'h00, 3'b000, 1'b1, "R4 increment wrap");
    drive(8'hFF, 8'hFF, 3'b001, 1'b1, "R4 max add");
    // R7: cin toggled in logic mode
    for (int s = 4; s < 8; s++) begin
      drive(8'hC3, 8'hA5, 3'(s), 1'b0, "R7 cin=0");
      drive(8'hC3, 8'hA5, 3'(s), 1'b1, "R7 cin=1");
    end
    // direct R7 check at the ports: result unchanged by cin
    @(posedge clk); a = 8'h3C; b = 8'h0F; sel = 3'b110; cin = 1'b0;
    @(negedge clk); lr0 = res;
    @(posedge clk); cin = 1'b1;
    @(negedge clk); expect_direct(res, lr0, "R7 xor ignores cin");
    expect_direct({{(W-2){1'b0}}, cy, ov}, '0, "R8 flags in logic mode");

    // all selects and cin on random and boundary operands
    for (int it = 0; it < 300; it++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (it % 10 == 0) ra = (it % 20 == 0) ? 8'h80 : 8'h7F;
      if (it % 15 == 0) rb = 8'hFF;
      for (int s = 0; s < 8; s++)
        for (int c = 0; c < 2; c++)
          drive(ra, rb, 3'(s), c[0], "");
    end

    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
    end
  end
endmodule